// File: doc/BRIEF.md
# Asynchronous Static RAM Strobe Controller

This block lets logic on a synchronous clock read and write one word at a time in an external asynchronous static RAM of 32K eight-bit words. The RAM's data pins carry both directions. Requests arrive over a valid/ready handshake with a 15-bit word address, a byte of write data and a write flag. The controller then drives the RAM's active-low select, write and output strobes, the address and the outgoing byte. It also drives a tri-state enable that the pad ring uses to turn the shared data pins around. Read data comes back with a one-cycle valid pulse.

Each RAM timing limit is a parameter in picoseconds. The clock period is a parameter too. Every limit becomes a whole number of clock cycles, rounded up, and a limit of zero still takes one cycle. Each transfer steps through four states: idle, address setup, strobe active, recovery. The strobe-active and recovery lengths depend on the direction of the transfer. An interlock counts the cycles since the output strobe last rose. The controller's data drivers stay off until the RAM has had its full turn-off time, so the two sides never drive the bus at the same time.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, select, write and output strobes are high (inactive), the data drive enable is low, rd_valid is low and req_ready is high.
- R2: req_ready falls in the cycle after a request is accepted. It stays low for exactly SU+ACC+REC cycles. A read takes 1 + max(ceil(tAA), ceil(tOE)) + max(ceil(tOHZ), ceil(tRC) − setup − access) cycles. A write takes 1 + max(ceil(tWP), ceil(tDW)) + max(1, ceil(tWC) − setup − access) cycles.
- R3: A read holds select low and write high. It gives one setup cycle with output strobe high, then holds the output strobe low for exactly max(ceil(tAA), ceil(tOE)) cycles.
- R4: rd_data holds the byte that sram_dq_in carried in the last cycle the output strobe was low. rd_valid is high for exactly one cycle per read, the cycle right after that one.
- R5: A write keeps the output strobe high throughout and holds the write strobe low for exactly max(ceil(tWP), ceil(tDW)) cycles.
- R6: The data drive enable goes high in the same cycle the write strobe falls. It stays high for one cycle after the write strobe rises. It is never high while the output strobe is low, and never before the output strobe has been high for ceil(tOHZ) cycles.
- R7: sram_addr holds the accepted address while select is low. sram_dq_out holds the accepted write byte while the drive enable is high.
- R8: Each cycle count is the time limit divided by the clock period, rounded up, with a minimum of one cycle.
- R9: The write and output strobes are never low together. The write strobe is low only while select is low.
- R10: Request fields are sampled only at acceptance. Changing them while a transfer is in progress has no effect on the strobes, address or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write byte |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | 8 | Read byte |
| sram_addr | output | 15 | Address to RAM |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output strobe, active low |
| sram_dq_out | output | 8 | Byte driven onto shared pins |
| sram_dq_oe | output | 1 | Tri-state enable for sram_dq_out |
| sram_dq_in | input | 8 | Byte seen on shared pins |

## Verification
A wrong state or a wrong phase count shows at the ports within the same transfer. The output strobe or write strobe stays low for the wrong number of cycles, and req_ready returns early or late. A broken turn-off interlock or a broken drive-enable term shows as the drive enable being high while the output strobe is low, or as the enable lasting other than one cycle past the write strobe. A capture on the wrong edge shows on the next read-back, because rd_data does not match the stored byte or rd_valid is not in the cycle after the output strobe rises.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACCESS  = 2'd2,
    ST_RECOVER = 2'd3
  } sc_state_e;

  // Convert a time limit into clock cycles, rounding up, never below one.
  function automatic int unsigned cycles_up(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned r;
    r = (t_ps + clk_ps - 1) / clk_ps;
    return (r == 0) ? 1 : r;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Cycles still missing so that used cycles reach a total; zero if already met.
  function automatic int unsigned shortfall(input int unsigned total, input int unsigned used);
    return (total > used) ? (total - used) : 0;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SU_R  = 1,
  parameter int unsigned RD    = 1,
  parameter int unsigned REC_R = 1,
  parameter int unsigned SU_W  = 1,
  parameter int unsigned WP    = 1,
  parameter int unsigned REC_W = 1,
  parameter int unsigned OHZ   = 1,
  parameter int unsigned CNT_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic is_write,
  output logic idle,
  output logic cs_n,
  output logic we_n,
  output logic oe_n,
  output logic drive_en,
  output logic rd_capture
);

  localparam int unsigned QW = $clog2(OHZ + 1);

  sc_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_q, wr_d;
  logic [QW-1:0]    quiet_q;
  logic             quiet_ok;
  logic             phase_done;
  logic             cs_n_d, we_n_d, oe_n_d, drive_d;

  assign phase_done = (cnt_q == '0);
  assign quiet_ok   = (quiet_q >= QW'(OHZ));
  assign idle       = (state_q == ST_IDLE);
  assign rd_capture = (state_q == ST_ACCESS) && !wr_q && phase_done;

  // Next state and phase counter
  always_comb begin
    state_d = state_q;
    cnt_d   = phase_done ? '0 : cnt_q - 1'b1;
    wr_d    = wr_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (start) begin
          state_d = ST_SETUP;
          wr_d    = is_write;
          cnt_d   = is_write ? CNT_W'(SU_W - 1) : CNT_W'(SU_R - 1);
        end
      end
      ST_SETUP: begin
        if (phase_done && (!wr_q || quiet_ok)) begin
          state_d = ST_ACCESS;
          cnt_d   = wr_q ? CNT_W'(WP - 1) : CNT_W'(RD - 1);
        end
      end
      ST_ACCESS: begin
        if (phase_done) begin
          state_d = ST_RECOVER;
          cnt_d   = wr_q ? CNT_W'(REC_W - 1) : CNT_W'(REC_R - 1);
        end
      end
      ST_RECOVER: begin
        if (phase_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobes decoded from the next state so they leave flops directly
  always_comb begin
    cs_n_d  = (state_d == ST_IDLE) || (state_d == ST_RECOVER);
    oe_n_d  = !((state_d == ST_ACCESS) && !wr_d);
    we_n_d  = !((state_d == ST_ACCESS) && wr_d);
    drive_d = wr_d && ((state_d == ST_ACCESS) ||
                       ((state_d == ST_RECOVER) && (state_q == ST_ACCESS)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      wr_q     <= 1'b0;
      cs_n     <= 1'b1;
      we_n     <= 1'b1;
      oe_n     <= 1'b1;
      drive_en <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      wr_q     <= wr_d;
      cs_n     <= cs_n_d;
      we_n     <= we_n_d;
      oe_n     <= oe_n_d;
      drive_en <= drive_d;
    end
  end

  // Turn-off interlock: cycles since the output strobe was last low
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        quiet_q <= '0;
    else if (!oe_n)    quiet_q <= '0;
    else if (!quiet_ok) quiet_q <= quiet_q + 1'b1;
  end

  AST_WE_OE_EXCL:   assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n)); // R9
  AST_WE_NEEDS_CS:  assert property (@(posedge clk) disable iff (!rst_n) !we_n |-> !cs_n); // R9
  AST_DRIVE_NOT_OE: assert property (@(posedge clk) disable iff (!rst_n) drive_en |-> oe_n); // R6
  AST_DRIVE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) drive_en |-> quiet_ok); // R6
  AST_DRIVE_TAIL:   assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> drive_en); // R6
  AST_DRIVE_AT_WE:  assert property (@(posedge clk) disable iff (!rst_n) $fell(we_n) |-> drive_en); // R6
  AST_BUSY_AFTER:   assert property (@(posedge clk) disable iff (!rst_n) start |=> !idle); // R2

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp #(
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr <= '0;
      dq_out    <= '0;
    end else if (load) begin
      sram_addr <= req_addr;
      dq_out    <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |=> !rd_valid); // R4
  AST_NO_LOAD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n) !$past(load) |-> $stable(sram_addr)); // R10

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 15,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 20000,
  parameter int unsigned T_RC_PS   = 15000,
  parameter int unsigned T_AA_PS   = 15000,
  parameter int unsigned T_OE_PS   = 7000,
  parameter int unsigned T_OHZ_PS  = 7000,
  parameter int unsigned T_WC_PS   = 15000,
  parameter int unsigned T_WP_PS   = 12000,
  parameter int unsigned T_DW_PS   = 8000,
  parameter int unsigned T_AS_PS   = 0,
  parameter int unsigned T_WR_PS   = 0,
  parameter int unsigned T_DH_PS   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned SU_R  = cycles_up(T_AS_PS, CLK_PS);
  localparam int unsigned RD    = max2(cycles_up(T_AA_PS, CLK_PS), cycles_up(T_OE_PS, CLK_PS));
  localparam int unsigned OHZ   = cycles_up(T_OHZ_PS, CLK_PS);
  localparam int unsigned REC_R = max2(OHZ, shortfall(cycles_up(T_RC_PS, CLK_PS), SU_R + RD));
  localparam int unsigned SU_W  = cycles_up(T_AS_PS, CLK_PS);
  localparam int unsigned WP    = max2(cycles_up(T_WP_PS, CLK_PS), cycles_up(T_DW_PS, CLK_PS));
  localparam int unsigned REC_W = max2(max2(cycles_up(T_WR_PS, CLK_PS), cycles_up(T_DH_PS, CLK_PS)),
                                       shortfall(cycles_up(T_WC_PS, CLK_PS), SU_W + WP));
  localparam int unsigned MAXC  = max2(max2(max2(SU_R, RD), max2(REC_R, SU_W)), max2(WP, REC_W));
  localparam int unsigned CNT_W = $clog2(MAXC + 1);

  logic start;
  logic idle;
  logic rd_capture;

  assign req_ready = idle;
  assign start     = req_valid && idle;

  sram_ctrl_fsm #(
    .SU_R (SU_R),
    .RD   (RD),
    .REC_R(REC_R),
    .SU_W (SU_W),
    .WP   (WP),
    .REC_W(REC_W),
    .OHZ  (OHZ),
    .CNT_W(CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_write  (req_write),
    .idle      (idle),
    .cs_n      (sram_cs_n),
    .we_n      (sram_we_n),
    .oe_n      (sram_oe_n),
    .drive_en  (sram_dq_oe),
    .rd_capture(rd_capture)
  );

  sram_ctrl_dp #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .capture  (rd_capture),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .dq_in    (sram_dq_in),
    .sram_addr(sram_addr),
    .dq_out   (sram_dq_out),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                                  (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr)); // R7
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                                  (sram_dq_oe && $past(sram_dq_oe)) |-> $stable(sram_dq_out)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                                   req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n)); // R1

endmodule

// File: tb/tb_sram_ctrl.sv
module tb_sram_ctrl;

  localparam int CLK_PS = 4000;   // timing arithmetic basis given to the controller
  localparam int T_RC = 15000, T_AA = 15000, T_OE = 7000, T_OHZ = 7000;
  localparam int T_WC = 15000, T_WP = 12000, T_DW = 8000, T_AS = 0, T_WR = 0, T_DH = 0;

  // vector: [23] write, [22:8] address, [7:0] write byte
  localparam int NV = 9;
  localparam logic [23:0] VEC [NV] = '{
    {1'b1, 15'h0005, 8'h11},
    {1'b1, 15'h7FC6, 8'h22},
    {1'b0, 15'h0005, 8'h00},
    {1'b0, 15'h7FC6, 8'h00},
    {1'b1, 15'h4A0C, 8'h5A},
    {1'b0, 15'h4A0C, 8'h00},
    {1'b0, 15'h0010, 8'h00},
    {1'b1, 15'h7FFF, 8'hFF},
    {1'b0, 15'h7FFF, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rd_valid, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [7:0]  rd_data, sram_dq_out, sram_dq_in;
  logic [14:0] sram_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];

  always #10ns clk = ~clk;

  sram_ctrl #(
    .CLK_PS(CLK_PS), .T_RC_PS(T_RC), .T_AA_PS(T_AA), .T_OE_PS(T_OE), .T_OHZ_PS(T_OHZ),
    .T_WC_PS(T_WC), .T_WP_PS(T_WP), .T_DW_PS(T_DW), .T_AS_PS(T_AS), .T_WR_PS(T_WR), .T_DH_PS(T_DH)
  ) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  // RAM model: drives only in read mode, stores while write strobe and drivers overlap
  always_comb sram_dq_in = (!sram_cs_n && sram_we_n && !sram_oe_n) ? mem[sram_addr[5:0]] : 8'hA5;
  always @(posedge clk) if (!sram_cs_n && !sram_we_n && sram_dq_oe) mem[sram_addr[5:0]] <= sram_dq_out;

  // R8: own rounding, written as quotient plus remainder test
  function automatic int cyc(input int t);
    int r;
    r = t / CLK_PS + ((t % CLK_PS) != 0 ? 1 : 0);
    if (r < 1) r = 1;
    return r;
  endfunction
  function automatic int bigger(input int a, input int b);
    return a > b ? a : b;
  endfunction

  int e_rd, e_rrec, e_rbusy, e_wp, e_wrec, e_wbusy;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic run_op(input logic w, input logic [14:0] a, input logic [7:0] d, input logic [7:0] exp_rd);
    int busy = 0, oe_lo = 0, we_lo = 0, drv = 0, rv = 0;
    int last_oe = -1, rv_idx = -1, first_drv = -1, first_we = -1, last_we = -1;
    bit addr_ok = 1, data_ok = 1, excl_ok = 1, clash = 0;
    logic [7:0] got = '0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    // R10: change every request field while the transfer runs
    req_valid = 1'b0; req_write = ~w; req_addr = ~a; req_wdata = ~d;
    for (int i = 1; i < 60; i++) begin
      if (req_ready) break;
      busy = i;
      if (!sram_cs_n && sram_addr != a) addr_ok = 0;
      if (!sram_oe_n) begin oe_lo++; last_oe = i; end
      if (!sram_we_n) begin
        we_lo++; last_we = i;
        if (first_we < 0) first_we = i;
        if (sram_cs_n) excl_ok = 0;
        if (!sram_oe_n) excl_ok = 0;
      end
      if (sram_dq_oe) begin
        drv++;
        if (first_drv < 0) first_drv = i;
        if (!sram_oe_n) clash = 1;
        if (sram_dq_out != d) data_ok = 0;
      end
      if (rd_valid) begin rv++; rv_idx = i; got = rd_data; end
      @(negedge clk);
    end
    chk(addr_ok, "R7 address held", 0, 1);
    chk(excl_ok, "R9 strobe exclusion", 0, 1);
    chk(!clash, "R6 drive with output strobe low", 1, 0);
    if (w) begin
      chk(busy == e_wbusy, "R2 write busy cycles", busy, e_wbusy);
      chk(we_lo == e_wp, "R5 write strobe cycles", we_lo, e_wp);
      chk(oe_lo == 0, "R5 output strobe during write", oe_lo, 0);
      chk(drv == we_lo + 1, "R6 drive cycles", drv, we_lo + 1);
      chk(first_drv == first_we, "R6 drive starts with write strobe", first_drv, first_we);
      chk(data_ok, "R7 write byte held", 0, 1);
      chk(rv == 0, "R4 no rd_valid on write", rv, 0);
      exp_mem[a[5:0]] = d;
    end else begin
      chk(busy == e_rbusy, "R2 read busy cycles", busy, e_rbusy);
      chk(oe_lo == e_rd, "R3 output strobe cycles", oe_lo, e_rd);
      chk(we_lo == 0 && drv == 0, "R3 no write strobe or drive", we_lo + drv, 0);
      chk(rv == 1, "R4 one rd_valid pulse", rv, 1);
      chk(rv_idx == last_oe + 1, "R4 rd_valid timing", rv_idx, last_oe + 1);
      chk(got == exp_rd, "R4 read data", got, exp_rd);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    e_rd    = bigger(cyc(T_AA), cyc(T_OE));
    e_rrec  = bigger(cyc(T_OHZ), cyc(T_RC) - 1 - e_rd);
    e_rbusy = 1 + e_rd + e_rrec;
    e_wp    = bigger(cyc(T_WP), cyc(T_DW));
    e_wrec  = bigger(1, bigger(bigger(cyc(T_WR), cyc(T_DH)), cyc(T_WC) - 1 - e_wp));
    e_wbusy = 1 + e_wp + e_wrec;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 3 + 1);
      exp_mem[i] = 8'(i * 3 + 1);
    end

    // R1: during and after reset
    repeat (3) @(negedge clk);
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high in reset", 0, 1);
    chk(!sram_dq_oe && !rd_valid, "R1 drive and valid low in reset", 1, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high after reset", 0, 1);
    chk(req_ready && !sram_dq_oe && !rd_valid, "R1 ready after reset", req_ready, 1);

    // R8: expected counts for this clock basis
    chk(e_rbusy == 7 && e_wbusy == 5, "R8 derived cycle counts", e_rbusy * 10 + e_wbusy, 75);

    for (int v = 0; v < NV; v++) begin
      logic [14:0] a;
      a = VEC[v][22:8];
      run_op(VEC[v][23], a, VEC[v][7:0], exp_mem[a[5:0]]);
    end

    // Corner: write directly followed by read of the same word
    run_op(1'b1, 15'h2A21, 8'hC3, 8'h00);
    run_op(1'b0, 15'h2A21, 8'h00, exp_mem[6'h21]);

    // R10: held-off request fields do not move the address while idle
    @(negedge clk);
    req_addr = 15'h1234;
    @(negedge clk);
    chk(sram_addr == 15'h2A21, "R10 address ignores idle inputs", int'(sram_addr), 'h2A21);

    // R1: reset in the middle of a write returns every strobe to idle
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'h0003; req_wdata = 8'h77;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(!sram_we_n, "R5 write strobe active before abort", int'(sram_we_n), 0);
    rst_n = 1'b0;
    #1ns;
    chk(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe, "R1 abort clears strobes", 0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready, "R1 ready after abort", int'(req_ready), 1);

    summary();
  end

endmodule